// File: doc/BRIEF.md
# Repeated Branch Message Collapser

This block sits in a trace encoder between the stage that forms branch messages and the stage that packs them into bytes. Each incoming message is a record with a kind code, an instruction count, a history word and an address. While collapsing is enabled, a non-synchronizing branch message that matches the last forwarded one in every field is absorbed. The block does not emit it. Instead it advances a small repeat counter. A tight loop that produces the same branch message on every pass therefore costs one message plus one repeat message, not one message per pass.

The pending count goes out as a repeat message in three cases: a different message arrives, a synchronizing message arrives, or collapsing is turned off. The repeat message always leaves before the message that ended the run, so the downstream order is kept. When the counter is full and one more identical message arrives, a repeat message carrying the full count is emitted in its place and counting starts again at one. Synchronizing messages are never absorbed. They also clear the stored message, so the branch message after a synchronizing one is always sent.

Both sides use valid/ready handshakes. The output is driven combinationally from the input and the internal state, with no output register.

Top module: `rpt_collapse`

## Requirements
- R1: After reset nothing is pending: with no input, out_valid is 0, and the first message offered is forwarded unchanged.
- R2: While rpt_en is 1, a message of kind 0 (direct), 1 (indirect) or 2 (indirect with history) that equals the last forwarded message in kind, icnt, hist and addr is accepted and produces no output. A difference in any single field, the history word included, causes the message to be forwarded.
- R3: When a message that is not absorbed arrives while the count is nonzero, a repeat message carrying the count is emitted first and the message is forwarded after it.
- R4: A repeat message has out_kind 7, the count on out_rcnt, and zero on out_icnt, out_hist and out_addr. A forwarded message carries its input fields and out_rcnt = 0.
- R5: Messages of kind 3 to 6 (synchronizing) are never absorbed, not even when they are identical to the previous message.
- R6: After a synchronizing message is forwarded, the next branch message is forwarded even if it equals the one stored before the synchronizing message.
- R7: With the count at its maximum of 255, one more identical message produces a repeat message with count 255 in its place, and the count restarts at 1.
- R8: While rpt_en is 0, no message is absorbed and every message passes through unchanged, after any pending count has been emitted.
- R9: An absorbed message is accepted even when out_ready is 0. While an output is waiting, in_ready is 0 for a repeat flush and the output stays unchanged until out_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_en | input | 1 | Enables collapsing of repeated branch messages |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Input message accepted this cycle |
| in_kind | input | 3 | Message kind code (0..6) |
| in_icnt | input | 16 | Instruction count field |
| in_hist | input | 32 | Branch history field |
| in_addr | input | 32 | Address field |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Downstream accepts the output message |
| out_kind | output | 3 | Output kind code (7 = repeat) |
| out_icnt | output | 16 | Output instruction count |
| out_hist | output | 32 | Output history word |
| out_addr | output | 32 | Output address |
| out_rcnt | output | 8 | Repeat count; nonzero only on repeat messages |

## Verification
The stimulus covers the collapsing rule from several directions. Runs of identical direct messages check that absorption and the flush order work. Two indirect-with-history messages that differ only in the history word show that every field takes part in the comparison. A synchronizing message that copies the stored branch shows that synchronizing kinds are kept apart from repeatable ones. A run long enough to fill the counter shows the wrap to a count of one, as distinct from a plain flush. Toggling the enable and holding out_ready low show that a pending count is flushed rather than dropped, and that an absorbed message needs no downstream space.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    parameter int ICNT_W = 16;
    parameter int HIST_W = 32;
    parameter int ADDR_W = 32;
    parameter int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_DIRECT         = 3'd0,
        K_INDIRECT       = 3'd1,
        K_INDIRECT_HIST  = 3'd2,
        K_PROG_SYNC      = 3'd3,
        K_DIRECT_SYNC    = 3'd4,
        K_INDIRECT_SYNC  = 3'd5,
        K_IND_HIST_SYNC  = 3'd6,
        K_REPEAT         = 3'd7
    } kind_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ICNT_W-1:0] icnt;
        logic [HIST_W-1:0] hist;
        logic [ADDR_W-1:0] addr;
    } msg_t;

    // Only plain branch kinds may be collapsed.
    function automatic logic repeatable(input logic [KIND_W-1:0] k);
        return (k == K_DIRECT) || (k == K_INDIRECT) || (k == K_INDIRECT_HIST);
    endfunction

endpackage

// File: rtl/rpt_match.sv
module rpt_match
    import rpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic keep,
    input  msg_t cur,
    output logic hit
);

    msg_t last_q;
    logic last_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_v <= 1'b0;
            last_q <= '0;
        end else if (load) begin
            last_v <= keep;
            last_q <= cur;
        end
    end

    assign hit = last_v && (last_q == cur);

    // R6: a load that is not kept leaves nothing to match against
    a_r6_invalidate: assert property (@(posedge clk) disable iff (rst)
        (load && !keep) |=> !hit);

endmodule

// File: rtl/rpt_count.sv
module rpt_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             restart,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             zero,
    output logic             full
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign zero = (cnt == '0);
    assign full = (cnt == CNT_MAX);

    // R7: after a wrap the count resumes at one
    a_r7_restart_one: assert property (@(posedge clk) disable iff (rst)
        (restart && !clear) |=> (cnt == 1));

    // R2: each absorbed message adds exactly one
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (inc && !restart && !clear) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rpt_collapse.sv
module rpt_collapse
    import rpt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rpt_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KIND_W-1:0] in_kind,
    input  logic [ICNT_W-1:0] in_icnt,
    input  logic [HIST_W-1:0] in_hist,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [KIND_W-1:0] out_kind,
    output logic [ICNT_W-1:0] out_icnt,
    output logic [HIST_W-1:0] out_hist,
    output logic [ADDR_W-1:0] out_addr,
    output logic [CNT_W-1:0]  out_rcnt
);

    msg_t             cur;
    logic             hit, match, sat, flush, emit_rpt;
    logic             fire_in, fire_out;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero, cnt_full;

    assign cur = '{kind: in_kind, icnt: in_icnt, hist: in_hist, addr: in_addr};

    rpt_match u_match (
        .clk  (clk),
        .rst  (rst),
        .load (fire_in && !match),
        .keep (rpt_en && repeatable(in_kind)),
        .cur  (cur),
        .hit  (hit)
    );

    rpt_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .inc     (fire_in && match && !sat),
        .restart (fire_in && sat),
        .clear   (fire_out && flush),
        .cnt     (cnt),
        .zero    (cnt_zero),
        .full    (cnt_full)
    );

    assign match    = rpt_en && repeatable(in_kind) && hit;
    assign sat      = match && cnt_full;
    assign flush    = !cnt_zero && !match;
    assign emit_rpt = flush || sat;

    assign out_valid = in_valid && (emit_rpt || !match);
    assign in_ready  = (match && !sat) ? 1'b1 : (flush ? 1'b0 : out_ready);
    assign fire_in   = in_valid && in_ready;
    assign fire_out  = out_valid && out_ready;

    always_comb begin
        if (emit_rpt) begin
            out_kind = K_REPEAT;
            out_icnt = '0;
            out_hist = '0;
            out_addr = '0;
            out_rcnt = cnt;
        end else begin
            out_kind = in_kind;
            out_icnt = in_icnt;
            out_hist = in_hist;
            out_addr = in_addr;
            out_rcnt = '0;
        end
    end

    // R4: a repeat message never reports an empty run
    a_r4_nonzero_count: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == K_REPEAT) |-> (out_rcnt != '0));

    // R5: an accepted synchronizing message leaves on the same cycle
    a_r5_sync_passes: assert property (@(posedge clk) disable iff (rst)
        (fire_in && !repeatable(in_kind)) |-> (out_valid && out_kind == in_kind));

    // R6: after a synchronizing message the next branch is forwarded
    a_r6_after_sync: assert property (@(posedge clk) disable iff (rst)
        ($past(fire_in && !repeatable(in_kind)) && in_valid && repeatable(in_kind))
        |-> (out_valid && out_kind == in_kind));

    // R9: an output stalled by downstream holds its contents
    a_r9_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !fire_in && $stable(in_kind) && $stable(in_valid))
        |=> (!in_valid || out_valid));

    // R3: a pending count blocks the input until it has been flushed
    a_r3_flush_first: assert property (@(posedge clk) disable iff (rst)
        (in_valid && flush) |-> (!in_ready && out_kind == K_REPEAT));

endmodule

// File: tb/test_rpt_collapse.sv
module test_rpt_collapse;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rpt_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_kind = '0;
    logic [15:0] in_icnt = '0;
    logic [31:0] in_hist = '0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_kind;
    logic [15:0] out_icnt;
    logic [31:0] out_hist;
    logic [31:0] out_addr;
    logic [7:0]  out_rcnt;

    int n_chk = 0;
    int n_bad = 0;

    logic [2:0]  lg_k [0:15];
    logic [15:0] lg_i [0:15];
    logic [31:0] lg_h [0:15];
    logic [31:0] lg_a [0:15];
    logic [7:0]  lg_r [0:15];
    int          lg_n = 0;

    always #5 clk = ~clk;

    rpt_collapse i_rpt_collapse (
        .clk(clk), .rst(rst), .rpt_en(rpt_en),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_icnt(in_icnt), .in_hist(in_hist), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_icnt(out_icnt), .out_hist(out_hist),
        .out_addr(out_addr), .out_rcnt(out_rcnt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] k, input logic [15:0] ic,
                        input logic [31:0] h, input logic [31:0] a);
        logic acc;
        @(negedge clk);
        in_kind = k; in_icnt = ic; in_hist = h; in_addr = a; in_valid = 1'b1;
        forever begin
            #1;
            if (out_valid && out_ready && lg_n < 16) begin
                lg_k[lg_n] = out_kind; lg_i[lg_n] = out_icnt; lg_h[lg_n] = out_hist;
                lg_a[lg_n] = out_addr; lg_r[lg_n] = out_rcnt; lg_n++;
            end
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic expect_msg(input string req, input int idx, input logic [2:0] k,
                              input logic [15:0] ic, input logic [31:0] h,
                              input logic [31:0] a, input logic [7:0] r);
        check(req, {lg_k[idx], lg_r[idx]}, {k, r});
        check(req, {lg_i[idx], lg_h[idx], lg_a[idx]}, {ic, h, a});
    endtask

    task automatic t_reset;
        #1;
        check("R1 idle out_valid", out_valid, 1'b0);
    endtask

    task automatic t_basic;
        lg_n = 0;
        send(3'd0, 16'd5, 32'h0, 32'h100);
        repeat (3) send(3'd0, 16'd5, 32'h0, 32'h100);
        check("R2 absorbed run", lg_n, 1);
        send(3'd1, 16'd7, 32'h0, 32'h200);
        check("R3 output count", lg_n, 3);
        expect_msg("R1 first forwarded", 0, 3'd0, 16'd5, 32'h0, 32'h100, 8'd0);
        expect_msg("R4 repeat fields", 1, 3'd7, 16'd0, 32'h0, 32'h0, 8'd3);
        expect_msg("R3 message after repeat", 2, 3'd1, 16'd7, 32'h0, 32'h200, 8'd0);
    endtask

    task automatic t_hist_diff;
        lg_n = 0;
        send(3'd2, 16'd4, 32'hAAAA, 32'h300);
        send(3'd2, 16'd4, 32'hBBBB, 32'h300);
        check("R2 hist differs count", lg_n, 2);
        expect_msg("R2 hist differs", 1, 3'd2, 16'd4, 32'hBBBB, 32'h300, 8'd0);
    endtask

    task automatic t_sync;
        lg_n = 0;
        send(3'd2, 16'd4, 32'hBBBB, 32'h300);
        send(3'd2, 16'd4, 32'hBBBB, 32'h300);
        send(3'd6, 16'd4, 32'hBBBB, 32'h300);
        check("R5 flush before sync count", lg_n, 2);
        expect_msg("R5 repeat before sync", 0, 3'd7, 16'd0, 32'h0, 32'h0, 8'd2);
        expect_msg("R5 sync forwarded", 1, 3'd6, 16'd4, 32'hBBBB, 32'h300, 8'd0);
        send(3'd2, 16'd4, 32'hBBBB, 32'h300);
        check("R6 branch after sync count", lg_n, 3);
        expect_msg("R6 branch after sync", 2, 3'd2, 16'd4, 32'hBBBB, 32'h300, 8'd0);
        send(3'd4, 16'd9, 32'h0, 32'h400);
        send(3'd4, 16'd9, 32'h0, 32'h400);
        check("R5 identical syncs both out", lg_n, 5);
        expect_msg("R5 second sync", 4, 3'd4, 16'd9, 32'h0, 32'h400, 8'd0);
    endtask

    task automatic t_sat;
        lg_n = 0;
        send(3'd0, 16'd1, 32'h0, 32'h500);
        for (int i = 0; i < 255; i++) send(3'd0, 16'd1, 32'h0, 32'h500);
        check("R7 255 absorbed", lg_n, 1);
        send(3'd0, 16'd1, 32'h0, 32'h500);
        check("R7 wrap count", lg_n, 2);
        expect_msg("R7 full repeat", 1, 3'd7, 16'd0, 32'h0, 32'h0, 8'd255);
        send(3'd1, 16'd2, 32'h0, 32'h600);
        check("R7 after wrap count", lg_n, 4);
        expect_msg("R7 restart at one", 2, 3'd7, 16'd0, 32'h0, 32'h0, 8'd1);
        expect_msg("R7 closing message", 3, 3'd1, 16'd2, 32'h0, 32'h600, 8'd0);
    endtask

    task automatic t_disable;
        lg_n = 0;
        send(3'd0, 16'd3, 32'h0, 32'h700);
        send(3'd0, 16'd3, 32'h0, 32'h700);
        rpt_en = 1'b0;
        send(3'd0, 16'd3, 32'h0, 32'h700);
        send(3'd0, 16'd3, 32'h0, 32'h700);
        check("R8 disabled count", lg_n, 4);
        expect_msg("R8 pending flushed", 1, 3'd7, 16'd0, 32'h0, 32'h0, 8'd1);
        expect_msg("R8 pass through", 3, 3'd0, 16'd3, 32'h0, 32'h700, 8'd0);
        rpt_en = 1'b1;
    endtask

    task automatic t_backpressure;
        lg_n = 0;
        send(3'd1, 16'd8, 32'h0, 32'h800);
        out_ready = 1'b0;
        send(3'd1, 16'd8, 32'h0, 32'h800);
        check("R9 absorbed without space", lg_n, 1);
        @(negedge clk);
        in_kind = 3'd0; in_icnt = 16'd6; in_hist = 32'h0; in_addr = 32'h900; in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            check("R9 stalled repeat", {out_valid, in_ready, out_kind, out_rcnt},
                  {1'b1, 1'b0, 3'd7, 8'd1});
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        check("R9 repeat released", {out_valid, in_ready, out_kind}, {1'b1, 1'b0, 3'd7});
        @(negedge clk);
        #1;
        check("R9 message next", {out_valid, in_ready, out_kind, out_addr},
              {1'b1, 1'b1, 3'd0, 32'h900});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_hist_diff();
        t_sync();
        t_sat();
        t_disable();
        t_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule